// File: doc/BRIEF.md
# Two-Stage Lookup-Table Logic Cell

This block is a programmable logic cell made of three lookup tables in two stages and two D flip-flops. The first stage has two four-input tables, one for each group of four logic inputs. The second stage has a three-input table. It combines the two first-stage results with one extra input. Each of the two outputs takes either its own first-stage table or the second-stage table. It can pass that value straight through, or pass it through its flip-flop. Each flip-flop can also capture an external data pin directly, without going through any table.

The cell starts in configuration mode. In that mode a 46-bit configuration word is shifted in serially, one bit per clock, lowest bit first. A done pulse then moves the cell to user mode, and the programmed function begins to drive the outputs. The cell can work as two independent four-variable functions. It can also work as one five-variable function: the two four-input tables hold the two halves of the truth table, and the second-stage table selects between them using the fifth input.

Top module: `lut_logic_cell`

## Requirements
- R1: When `rst` is high at a rising edge, the cell returns to configuration mode, the configuration word is cleared to 0 and both flip-flops are cleared to 0, so both outputs read 0 afterwards.
- R2: In configuration mode, each clock with `cfg_shift` high shifts `cfg_bit` in at the top of the 46-bit word, and the whole word moves down by one. After 46 shifts, the first bit sent sits at bit 0. Word layout: bits 15:0 are the first X-side table, bits 31:16 the first Y-side table, bits 39:32 the second-stage table, bit 40 / 41 select the second-stage table for X / Y, bit 42 / 43 make the X / Y flip-flop capture `ext_x` / `ext_y`, and bit 44 / 45 make X / Y registered.
- R3: A `cfg_done` pulse in configuration mode puts the cell in user mode from the next clock edge on.
- R4: In user mode, with its select bit and register bit at 0, `out_x` equals the X-side table entry at index `f_in`, and `out_y` equals the Y-side table entry at index `g_in`. Input bit 0 is the least significant index bit.
- R5: With its select bit at 1, an output shows the second-stage table entry at index {`h_in`, Y-side result, X-side result}, where the X-side result is index bit 0.
- R6: With the X-side table holding truth-table entries 15:0, the Y-side table holding entries 31:16, the second-stage table set to 8'hCA, bit 40 set, and the same 4-bit value on `f_in` and `g_in`, `out_x` realizes any five-input function indexed by {`h_in`, `f_in`}.
- R7: In configuration mode both outputs are 0 whatever the tables hold, and the flip-flops stay at 0.
- R8: A registered output shows its flip-flop. The flip-flop loads at a rising edge only when `ce` is high, and otherwise it holds.
- R9: With its capture bit set, a flip-flop loads its external data pin and ignores the table path.
- R10: In user mode, `cfg_shift` and `cfg_done` have no effect, and the configured function is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the flip-flops |
| rst | input | 1 | Synchronous active-high reset, returns to configuration mode |
| cfg_shift | input | 1 | Shift one configuration bit this clock |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | input | 1 | Ends configuration and enters user mode |
| ce | input | 1 | Clock enable for both flip-flops |
| f_in | input | 4 | Index of the X-side first-stage table |
| g_in | input | 4 | Index of the Y-side first-stage table |
| h_in | input | 1 | Extra input of the second-stage table |
| ext_x | input | 1 | Direct data for the X flip-flop |
| ext_y | input | 1 | Direct data for the Y flip-flop |
| out_x | output | 1 | X output, combinational or registered |
| out_y | output | 1 | Y output, combinational or registered |

## Verification
The bench loads a set of configuration words and compares every one of the 512 input combinations against a truth table it computes from those bits. A design with a shift direction that is off by one, swapped table halves, or reversed index bits fails most of these comparisons. A five-variable truth table built from both first-stage tables and a 2:1 selecting second stage catches a second stage wired to the wrong index order. Directed tests cover the following:
- outputs that leak in configuration mode;
- a flip-flop that ignores `ce`;
- an external capture that still follows the table;
- configuration that can be shifted, or re-triggered, after done;
- a reset that leaves the cell in user mode.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int LUT_K   = 4;
  localparam int LUT_N   = 1 << LUT_K;
  localparam int H_K     = 3;
  localparam int H_N     = 1 << H_K;
  localparam int NUM_OUT = 2;

  // Packed so that the first table lands at bit 0 of the word.
  typedef struct packed {
    logic [NUM_OUT-1:0] reg_out;
    logic [NUM_OUT-1:0] use_ext;
    logic [NUM_OUT-1:0] sel_h;
    logic [H_N-1:0]     h_tbl;
    logic [LUT_N-1:0]   g_tbl;
    logic [LUT_N-1:0]   f_tbl;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tbl,
  input  logic [K-1:0] idx,
  output logic         y
);
  assign y = tbl[idx];
endmodule

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         done,
  output logic [W-1:0] cfg,
  output logic         user_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      user_mode <= 1'b0;
    end else if (!user_mode) begin
      if (shift_en) cfg <= {shift_bit, cfg[W-1:1]};
      if (done)     user_mode <= 1'b1;
    end
  end

  // R3: done in configuration mode enters user mode
  a_r3_done_enters_user: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && done) |=> user_mode);

  // R10: user mode freezes the configuration and stays
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    user_mode |=> (user_mode && $stable(cfg)));

  // R2: a shift moves the incoming bit to the top of the word
  a_r2_shift_in_top: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && shift_en) |=> (cfg[W-1] == $past(shift_bit)));
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
  input  logic clk,
  input  logic rst,
  input  logic user_mode,
  input  logic ce,
  input  logic d_comb,
  input  logic d_ext,
  input  logic use_ext,
  input  logic reg_out,
  output logic out
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst || !user_mode) q <= 1'b0;
    else if (ce)           q <= use_ext ? d_ext : d_comb;
  end

  always_comb begin
    if (!user_mode)   out = 1'b0;
    else if (reg_out) out = q;
    else              out = d_comb;
  end

  // R7: flip-flop held clear in configuration mode
  a_r7_ff_held_clear: assert property (@(posedge clk) disable iff (rst)
    !user_mode |=> (q == 1'b0));

  // R8: clock enable low holds the flip-flop
  a_r8_ce_hold: assert property (@(posedge clk) disable iff (rst)
    (user_mode && !ce) |=> (q == $past(q)));

  // R9: loads the chosen data source when enabled
  a_r9_capture_source: assert property (@(posedge clk) disable iff (rst)
    (user_mode && ce) |=> (q == $past(use_ext ? d_ext : d_comb)));
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lut_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift,
  input  logic             cfg_bit,
  input  logic             cfg_done,
  input  logic             ce,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             h_in,
  input  logic             ext_x,
  input  logic             ext_y,
  output logic             out_x,
  output logic             out_y
);
  logic [CFG_W-1:0]   cfg_bits;
  cell_cfg_t          cfg;
  logic               user_mode;
  logic               f_y, g_y, h_y;
  logic [NUM_OUT-1:0] stage1, comb, ext, outs;

  lut_cell_cfg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_shift), .shift_bit(cfg_bit),
    .done(cfg_done), .cfg(cfg_bits), .user_mode(user_mode)
  );
  assign cfg = cell_cfg_t'(cfg_bits);

  lut_table #(.K(LUT_K)) u_f (.tbl(cfg.f_tbl), .idx(f_in), .y(f_y));
  lut_table #(.K(LUT_K)) u_g (.tbl(cfg.g_tbl), .idx(g_in), .y(g_y));
  lut_table #(.K(H_K))   u_h (.tbl(cfg.h_tbl), .idx({h_in, g_y, f_y}), .y(h_y));

  assign stage1 = {g_y, f_y};
  assign ext    = {ext_y, ext_x};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign comb[i] = cfg.sel_h[i] ? h_y : stage1[i];
    lut_cell_ff u_ff (
      .clk(clk), .rst(rst), .user_mode(user_mode), .ce(ce),
      .d_comb(comb[i]), .d_ext(ext[i]), .use_ext(cfg.use_ext[i]),
      .reg_out(cfg.reg_out[i]), .out(outs[i])
    );
  end

  assign out_x = outs[0];
  assign out_y = outs[1];

  // R7: configuration mode keeps both outputs at 0
  a_r7_outputs_quiet: assert property (@(posedge clk) disable iff (rst)
    !user_mode |-> (out_x == 1'b0 && out_y == 1'b0));

  // R1: reset leaves configuration mode active
  a_r1_reset_to_cfg: assert property (@(posedge clk)
    rst |=> !user_mode);
endmodule

// File: tb/lut_logic_cell_tb.sv
module lut_logic_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 46;
  localparam int NCFG = 8;
  localparam logic [W-1:0] CFG_TAB [NCFG] = '{
    46'h0_0_00_0000_FFFF,
    46'h0_3_E8_8000_FFFE,
    46'h0_1_96_6996_8001,
    46'h0_2_CA_1234_ABCD,
    46'h0_F_7F_0F0F_00FF,
    46'h0_0_01_DEAD_BEEF,
    46'h0_3_80_F0F0_CCCC,
    46'h0_1_FE_7FFF_0001
  };

  logic clk = 0, rst = 1, cfg_shift = 0, cfg_bit = 0, cfg_done = 0, ce = 0;
  logic [3:0] f_in = 0, g_in = 0;
  logic h_in = 0, ext_x = 0, ext_y = 0;
  logic out_x, out_y;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_logic_cell u_dut (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .ce(ce), .f_in(f_in), .g_in(g_in), .h_in(h_in),
    .ext_x(ext_x), .ext_y(ext_y), .out_x(out_x), .out_y(out_y)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic shift_word(input logic [W-1:0] c);
    for (int i = 0; i < W; i++) begin
      cfg_shift = 1; cfg_bit = c[i];
      @(negedge clk);
    end
    cfg_shift = 0; cfg_bit = 0;
  endtask

  task automatic pulse_done();
    cfg_done = 1; @(negedge clk); cfg_done = 0;
  endtask

  function automatic logic exp_out(input logic [W-1:0] c, input int side,
                                   input logic [3:0] f, input logic [3:0] g,
                                   input logic h);
    logic fx, gy, hv;
    fx = c[f];
    gy = c[16 + g];
    hv = c[32 + {h, gy, fx}];
    if (side == 0) return c[40] ? hv : fx;
    return c[41] ? hv : gy;
  endfunction

  task automatic sweep(input logic [W-1:0] c, input int step);
    for (int k = 0; k < 512; k += step) begin
      f_in = k[3:0]; g_in = k[7:4]; h_in = k[8];
      #1;
      check(out_x, exp_out(c, 0, f_in, g_in, h_in), "R4/R5 out_x");
      check(out_y, exp_out(c, 1, f_in, g_in, h_in), "R4/R5 out_y");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] c;
    logic [31:0] t;
    // R1: reset state
    do_reset();
    f_in = 4'hF; g_in = 4'hF; h_in = 1; #1;
    check(out_x, 1'b0, "R1 reset out_x");
    check(out_y, 1'b0, "R1 reset out_y");

    // R2/R4/R5: table-driven sweep of all inputs per configuration
    for (int n = 0; n < NCFG; n++) begin
      do_reset();
      shift_word(CFG_TAB[n]);
      pulse_done();
      sweep(CFG_TAB[n], 1);
    end

    // R7: loaded tables, no done yet -> outputs stay 0
    do_reset();
    shift_word(46'h0_0_00_FFFF_FFFF);
    f_in = 4'h3; g_in = 4'h5; #1;
    check(out_x, 1'b0, "R7 cfg mode out_x");
    check(out_y, 1'b0, "R7 cfg mode out_y");
    // R3: done enters user mode
    pulse_done(); #1;
    check(out_x, 1'b1, "R3 user mode out_x");
    check(out_y, 1'b1, "R3 user mode out_y");

    // R10: shifting and done in user mode ignored
    @(negedge clk);
    shift_word({W{1'b0}});
    pulse_done();
    sweep(46'h0_0_00_FFFF_FFFF, 7);

    // R6: five-input function
    t = 32'hB3C5_19E7;
    c = {2'b00, 2'b00, 2'b01, 8'hCA, t[31:16], t[15:0]};
    do_reset(); shift_word(c); pulse_done();
    for (int k = 0; k < 32; k++) begin
      f_in = k[3:0]; g_in = k[3:0]; h_in = k[4]; #1;
      check(out_x, t[k], "R6 five-input function");
    end

    // R8: registered X = AND4 of f_in, ce gating
    c = {2'b01, 2'b00, 2'b00, 8'h00, 16'h0000, 16'h8000};
    do_reset(); shift_word(c); pulse_done();
    ce = 1; f_in = 4'hF; #1;
    check(out_x, 1'b0, "R8 registered before edge");
    @(negedge clk);
    check(out_x, 1'b1, "R8 registered after edge");
    ce = 0; f_in = 4'h0;
    @(negedge clk); @(negedge clk);
    check(out_x, 1'b1, "R8 ce low holds");
    ce = 1;
    @(negedge clk);
    check(out_x, 1'b0, "R8 ce high loads");

    // R9: Y registered from ext_y, table says 1 everywhere
    c = {2'b10, 2'b10, 2'b00, 8'h00, 16'hFFFF, 16'h0000};
    do_reset(); shift_word(c); pulse_done();
    ce = 1; ext_y = 0; g_in = 4'h7;
    @(negedge clk);
    check(out_y, 1'b0, "R9 ext capture 0 ignores table");
    ext_y = 1;
    @(negedge clk);
    check(out_y, 1'b1, "R9 ext capture 1");

    // R1: reset from user mode clears flip-flop and returns to cfg mode
    rst = 1; @(negedge clk); rst = 0; #1;
    check(out_y, 1'b0, "R1 reset from user mode");
    @(negedge clk);
    check(out_y, 1'b0, "R1 stays in cfg mode after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule